// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block drives frame transmission from a circular ring of descriptors held in a memory beside it. Each ring entry is two 32-bit words. The first word is a buffer address and the second is a control word. The control word carries the frame length, a buffer index, an end-of-frame mark and an abort request. For each piece of pending work, the engine reads both words. It then offers the length and buffer address to the MAC over a valid/ready handshake and waits for the MAC to report the result. Finally it writes a one-word completion status into a second, parallel ring.

Software sets up the two rings through a small register port. It gives each ring a base address and current pointer, and gives the descriptor ring size in bytes. It queues work by writing a count to the enqueue register and starts fetching by setting the transmit enable bit. Each completion raises a transmit-complete interrupt flag. The flag is cleared by reading the clear-on-read view of the interrupt status.

Memory is a synchronous port. A read issued in one cycle returns `mem_rdata` on the next cycle. A write completes in the cycle it is issued. The MAC offer follows valid/ready rules. Once `mac_valid` rises, it stays high and `mac_len`/`mac_buf` stay stable until the cycle in which `mac_ready` is high. `mac_done` is accepted only after the offer has been taken.

Register word offsets on `reg_addr`:
- 0: control, bit 0 = transmit enable
- 1: descriptor base
- 2: ring size in bytes
- 3: descriptor current pointer
- 4: status base
- 5: status current pointer
- 6: enqueue, write only
- 7: interrupt enable
- 8: interrupt status, plain view
- 9: interrupt status, clear-on-read view
- 10: pending count

A read returns its data on `reg_rdata` one cycle after `reg_rd`.

Top module: `txdq_engine`

## Requirements
- R1: After reset, `tx_irq`, `mac_valid` and `mem_req` are low, and the pending count and both current pointers read 0.
- R2: No memory request is issued while the transmit enable bit (control bit 0) is clear, even with work pending.
- R3: For each entry, the engine reads the word at the descriptor pointer and then the word at pointer+4. It presents the first word on `mac_buf` and control bits 11:0 on `mac_len`. The control word layout is: bit 31 end of frame, bits 30:16 buffer index, bit 15 abort, bits 11:0 length.
- R4: While `mac_valid` is high and `mac_ready` is low, `mac_valid`, `mac_len` and `mac_buf` hold.
- R5: The completion status written at the status pointer has the following bits:
  - bit 31 = 1
  - bit 30 = success
  - bit 29 = aborted
  - bit 26 = out-of-window collision
  - bit 25 = underrun
  - bit 24 = excessive collisions
  - bits 20:16 = collision count
  - bits 14:0 = the descriptor's buffer index (copied even if it differs from the entry number)
  - all other bits 0
- R6: A descriptor with control bit 15 set is never offered to the MAC. Its status has bit 29 set and bits 30, 26:24 and 20:16 clear.
- R7: Writing N to the enqueue register adds N to the pending count, and each completion subtracts 1. The engine idles at a count of 0.
- R8: The descriptor pointer advances by 8 per completion and returns to the base when it reaches base + ring size.
- R9: The status pointer advances by 4 per completion and wraps after the same number of entries, returning to the status base.
- R10: Each completion sets interrupt status bit 3. `tx_irq` is that bit ANDed with interrupt-enable bit 3. A read of the clear-on-read view returns the bit and clears it; a read of the plain view does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (status) when high, read (descriptor) when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Status word to write |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| mac_valid | output | 1 | Frame offer valid |
| mac_ready | input | 1 | MAC accepts the offer |
| mac_len | output | 12 | Frame length in bytes |
| mac_buf | output | 32 | Frame buffer address |
| mac_done | input | 1 | One-cycle pulse: transmission result is present |
| mac_ok | input | 1 | Frame sent successfully |
| mac_coll | input | 5 | Collision count |
| mac_excoll | input | 1 | Excessive collisions |
| mac_late | input | 1 | Out-of-window collision |
| mac_underrun | input | 1 | Transmit underrun |
| tx_irq | output | 1 | Transmit-complete interrupt |

## Verification
The first pattern queues work with the enable bit clear, then sets it. This separates the gating of fetches from the counting of pending work. Two clean frames follow, offered against a MAC that holds `mac_ready` low for a varying number of cycles, so the offer-hold rule is exercised. A second batch crosses the ring end. It mixes the following cases:
- an aborted descriptor, which must bypass the MAC
- a failed frame with underrun and a full collision count
- a frame whose buffer index differs from its slot, which shows the status copies the index rather than the slot number

Interrupt reads through both views show which one clears the flag.

// File: rtl/txdq_pkg.sv
package txdq_pkg;
  // register word offsets
  localparam logic [3:0] RA_CTRL  = 4'd0;
  localparam logic [3:0] RA_DBASE = 4'd1;
  localparam logic [3:0] RA_RSIZE = 4'd2;
  localparam logic [3:0] RA_DCUR  = 4'd3;
  localparam logic [3:0] RA_SBASE = 4'd4;
  localparam logic [3:0] RA_SCUR  = 4'd5;
  localparam logic [3:0] RA_ENQ   = 4'd6;
  localparam logic [3:0] RA_IEN   = 4'd7;
  localparam logic [3:0] RA_IRAW  = 4'd8;
  localparam logic [3:0] RA_ICLR  = 4'd9;
  localparam logic [3:0] RA_PEND  = 4'd10;

  localparam int IRQ_TX_BIT = 3;
  localparam int DESC_BYTES = 8;
  localparam int STS_BYTES  = 4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_RD_BUF, SQ_RD_CTL, SQ_DECODE, SQ_OFFER, SQ_WAIT, SQ_STATUS
  } seq_state_e;

  typedef struct packed {
    logic        ok;
    logic        abort;
    logic        late;
    logic        under;
    logic        excoll;
    logic [4:0]  coll;
    logic [14:0] idx;
  } tx_result_t;

  function automatic logic [31:0] pack_status(input tx_result_t r);
    logic [31:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[30]    = r.ok;
    w[29]    = r.abort;
    w[26]    = r.late;
    w[25]    = r.under;
    w[24]    = r.excoll;
    w[20:16] = r.coll;
    w[14:0]  = r.idx;
    return w;
  endfunction
endpackage

// File: rtl/txdq_ring_ptr.sv
module txdq_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] span,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] cur_q, nxt, off;

  always_comb begin
    nxt = cur_q + AW'(STEP);
    off = nxt - base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur_q <= '0;
    else if (load) cur_q <= load_val;
    else if (adv)  cur_q <= (off >= span) ? base : nxt;
  end

  assign cur = cur_q;

  AST_PTR_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (cur_q == $past(cur_q) + AW'(STEP)) || (cur_q == $past(base))); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(cur_q)); // R9
endmodule

// File: rtl/txdq_csr.sv
module txdq_csr
  import txdq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             done,
  input  logic [AW-1:0]    desc_cur,
  input  logic [AW-1:0]    sts_cur,
  output logic             tx_en,
  output logic [AW-1:0]    desc_base,
  output logic [AW-1:0]    ring_bytes,
  output logic [AW-1:0]    sts_base,
  output logic             desc_load,
  output logic             sts_load,
  output logic [AW-1:0]    load_val,
  output logic [CNT_W-1:0] pending,
  output logic             irq
);
  logic             en_q, ien_q, raw_q;
  logic [AW-1:0]    dbase_q, rsize_q, sbase_q;
  logic [CNT_W-1:0] pend_q;
  logic             enq_hit, clr_rd;

  assign enq_hit   = reg_wr && (reg_addr == RA_ENQ);
  assign clr_rd    = reg_rd && (reg_addr == RA_ICLR);
  assign desc_load = reg_wr && (reg_addr == RA_DCUR);
  assign sts_load  = reg_wr && (reg_addr == RA_SCUR);
  assign load_val  = reg_wdata[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ien_q   <= 1'b0;
      dbase_q <= '0;
      rsize_q <= '0;
      sbase_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL:  en_q    <= reg_wdata[0];
        RA_DBASE: dbase_q <= reg_wdata[AW-1:0];
        RA_RSIZE: rsize_q <= reg_wdata[AW-1:0];
        RA_SBASE: sbase_q <= reg_wdata[AW-1:0];
        RA_IEN:   ien_q   <= reg_wdata[IRQ_TX_BIT];
        default: ;
      endcase
    end
  end

  // pending work count: enqueue adds, completion subtracts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= pend_q + (enq_hit ? reg_wdata[CNT_W-1:0] : '0) - CNT_W'(done);
  end

  // transmit-complete flag: a new completion wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= 1'b0;
    else if (done)   raw_q <= 1'b1;
    else if (clr_rd) raw_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:          reg_rdata <= {31'b0, en_q};
        RA_DBASE:         reg_rdata <= 32'(dbase_q);
        RA_RSIZE:         reg_rdata <= 32'(rsize_q);
        RA_DCUR:          reg_rdata <= 32'(desc_cur);
        RA_SBASE:         reg_rdata <= 32'(sbase_q);
        RA_SCUR:          reg_rdata <= 32'(sts_cur);
        RA_IEN:           reg_rdata <= 32'(ien_q) << IRQ_TX_BIT;
        RA_IRAW, RA_ICLR: reg_rdata <= 32'(raw_q) << IRQ_TX_BIT;
        RA_PEND:          reg_rdata <= 32'(pend_q);
        default:          reg_rdata <= '0;
      endcase
    end
  end

  assign tx_en      = en_q;
  assign desc_base  = dbase_q;
  assign ring_bytes = rsize_q;
  assign sts_base   = sbase_q;
  assign pending    = pend_q;
  assign irq        = raw_q & ien_q;

  AST_PEND_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !enq_hit) |=> pend_q == $past(pend_q) - CNT_W'(1)); // R7
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !done) |=> !irq); // R10
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ien_q && !(reg_wr && reg_addr == RA_IEN)) |=> irq); // R10
endmodule

// File: rtl/txdq_seq.sv
module txdq_seq
  import txdq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [CNT_W-1:0] pending,
  input  logic [AW-1:0]    desc_cur,
  input  logic [AW-1:0]    sts_cur,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             mac_valid,
  input  logic             mac_ready,
  output logic [LEN_W-1:0] mac_len,
  output logic [31:0]      mac_buf,
  input  logic             mac_done,
  input  logic             mac_ok,
  input  logic [4:0]       mac_coll,
  input  logic             mac_excoll,
  input  logic             mac_late,
  input  logic             mac_underrun,
  output logic             done
);
  seq_state_e       st_q, st_d;
  logic [31:0]      buf_q;
  logic [LEN_W-1:0] len_q;
  tx_result_t       res_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE:   if (tx_en && pending != '0) st_d = SQ_RD_BUF;
      SQ_RD_BUF: st_d = SQ_RD_CTL;
      SQ_RD_CTL: st_d = SQ_DECODE;
      SQ_DECODE: st_d = mem_rdata[15] ? SQ_STATUS : SQ_OFFER;
      SQ_OFFER:  if (mac_ready) st_d = SQ_WAIT;
      SQ_WAIT:   if (mac_done) st_d = SQ_STATUS;
      SQ_STATUS: st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      buf_q <= '0;
      len_q <= '0;
      res_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SQ_RD_CTL) buf_q <= mem_rdata;
      if (st_q == SQ_DECODE) begin
        len_q       <= mem_rdata[LEN_W-1:0];
        res_q       <= '0;
        res_q.idx   <= mem_rdata[30:16];
        res_q.abort <= mem_rdata[15];
      end
      if (st_q == SQ_WAIT && mac_done) begin
        res_q.ok     <= mac_ok;
        res_q.late   <= mac_late;
        res_q.under  <= mac_underrun;
        res_q.excoll <= mac_excoll;
        res_q.coll   <= mac_coll;
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_cur;
    mem_wdata = '0;
    case (st_q)
      SQ_RD_BUF: mem_req = 1'b1;
      SQ_RD_CTL: begin
        mem_req  = 1'b1;
        mem_addr = desc_cur + AW'(4);
      end
      SQ_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sts_cur;
        mem_wdata = pack_status(res_q);
      end
      default: ;
    endcase
  end

  assign mac_valid = (st_q == SQ_OFFER);
  assign mac_len   = len_q;
  assign mac_buf   = buf_q;
  assign done      = (st_q == SQ_STATUS);

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && !mac_ready) |=> mac_valid && $stable(mac_len) && $stable(mac_buf)); // R4
  AST_GATED_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !tx_en) |=> !mem_req); // R2
  AST_ABORT_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_DECODE && mem_rdata[15]) |=> !mac_valid && done); // R6
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/txdq_engine.sv
module txdq_engine
  import txdq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             mac_valid,
  input  logic             mac_ready,
  output logic [LEN_W-1:0] mac_len,
  output logic [31:0]      mac_buf,
  input  logic             mac_done,
  input  logic             mac_ok,
  input  logic [4:0]       mac_coll,
  input  logic             mac_excoll,
  input  logic             mac_late,
  input  logic             mac_underrun,
  output logic             tx_irq
);
  logic             tx_en, done, desc_load, sts_load;
  logic [AW-1:0]    desc_base, ring_bytes, sts_base, sts_span, load_val;
  logic [AW-1:0]    desc_cur, sts_cur;
  logic [CNT_W-1:0] pending;

  // status ring holds one word per descriptor entry
  assign sts_span = (ring_bytes / AW'(DESC_BYTES)) * AW'(STS_BYTES);

  txdq_csr #(.AW(AW), .CNT_W(CNT_W)) u_csr (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .done, .desc_cur, .sts_cur, .tx_en, .desc_base, .ring_bytes, .sts_base,
    .desc_load, .sts_load, .load_val, .pending, .irq(tx_irq)
  );

  txdq_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_desc_ptr (
    .clk, .rst_n, .base(desc_base), .span(ring_bytes), .load(desc_load),
    .load_val, .adv(done), .cur(desc_cur)
  );

  txdq_ring_ptr #(.AW(AW), .STEP(STS_BYTES)) u_sts_ptr (
    .clk, .rst_n, .base(sts_base), .span(sts_span), .load(sts_load),
    .load_val, .adv(done), .cur(sts_cur)
  );

  txdq_seq #(.AW(AW), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
    .clk, .rst_n, .tx_en, .pending, .desc_cur, .sts_cur,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .mac_valid, .mac_ready, .mac_len, .mac_buf, .mac_done, .mac_ok,
    .mac_coll, .mac_excoll, .mac_late, .mac_underrun, .done
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tx_irq && !mac_valid); // R1
endmodule

// File: tb/tb_txdq_engine.sv
module tb_txdq_engine;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mac_valid, mac_ready = 0;
  logic [11:0] mac_len;
  logic [31:0] mac_buf;
  logic        mac_done = 0, mac_ok = 0, mac_excoll = 0, mac_late = 0, mac_underrun = 0;
  logic [4:0]  mac_coll = 0;
  logic        tx_irq;

  always #(CLK_NS/2) clk = ~clk;

  txdq_engine dut (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .mac_valid, .mac_ready, .mac_len, .mac_buf, .mac_done, .mac_ok,
    .mac_coll, .mac_excoll, .mac_late, .mac_underrun, .tx_irq
  );

  // memory model with a bench loading port
  logic [31:0] mem [0:255];
  logic        tb_wr = 0;
  logic [7:0]  tb_waddr = 0;
  logic [31:0] tb_wdata = 0;
  always @(posedge clk) begin
    if (tb_wr) mem[tb_waddr] <= tb_wdata;
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
  end

  int n_chk = 0, n_bad = 0, n_memreq = 0, n_frames = 0;
  logic [31:0] q_sts_word[$], q_sts_addr[$], q_len[$], q_buf[$];
  logic [8:0]  q_res[$]; // {ok, excoll, late, under, coll}

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic put_word(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk); tb_wr = 1; tb_waddr = byte_addr[9:2]; tb_wdata = d;
    @(negedge clk); tb_wr = 0;
  endtask

  // driver: load one descriptor and push the expected results
  task automatic send(input int entry, input logic [31:0] bufa, input logic [11:0] len,
                      input logic [14:0] idx, input logic abort, input logic ok,
                      input logic excoll, input logic late, input logic under,
                      input logic [4:0] coll);
    logic [31:0] da, ctl, sts;
    da  = 32'h100 + 32'(entry * 8);
    ctl = {1'b1, idx, abort, 3'b000, len};
    put_word(da, bufa);
    put_word(da + 4, ctl);
    if (abort) sts = {1'b1, 1'b0, 1'b1, 2'b00, 3'b000, 3'b000, 5'd0, 1'b0, idx};
    else begin
      sts = {1'b1, ok, 1'b0, 2'b00, late, under, excoll, 3'b000, coll, 1'b0, idx};
      q_len.push_back(32'(len));
      q_buf.push_back(bufa);
      q_res.push_back({ok, excoll, late, under, coll});
    end
    q_sts_word.push_back(sts);
    q_sts_addr.push_back(32'h200 + 32'(entry * 4));
  endtask

  // monitor: status writes against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req) n_memreq++;
    if (rst_n && mem_req && mem_we) begin
      if (q_sts_word.size() == 0) check("R5 unexpected status write", mem_addr, 32'hFFFF_FFFF);
      else begin
        check("R5 status word", mem_wdata, q_sts_word.pop_front());
        check("R9 status address", mem_addr, q_sts_addr.pop_front());
      end
    end
  end

  // MAC responder with varying back-pressure
  initial begin
    logic [8:0] r;
    forever begin
      @(negedge clk);
      if (mac_valid) begin
        n_frames++;
        repeat (n_frames % 3) @(negedge clk);
        if (q_len.size() == 0) check("R6 unexpected MAC offer", 32'(mac_len), 32'hFFFF_FFFF);
        else begin
          check("R3 length", 32'(mac_len), q_len.pop_front());
          check("R3 buffer address", mac_buf, q_buf.pop_front());
          r = q_res.pop_front();
        end
        mac_ready = 1;
        @(negedge clk); mac_ready = 0;
        repeat (2) @(negedge clk);
        {mac_ok, mac_excoll, mac_late, mac_underrun, mac_coll} = r;
        mac_done = 1;
        @(negedge clk); mac_done = 0;
      end
    end
  end

  task automatic drain();
    while (q_sts_word.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq after reset", 32'(tx_irq), 0);
    check("R1 mac_valid after reset", 32'(mac_valid), 0);
    check("R1 mem_req after reset", 32'(mem_req), 0);
    reg_read(4'd10, d); check("R1 pending after reset", d, 0);
    reg_read(4'd3, d);  check("R1 descriptor pointer after reset", d, 0);

    reg_write(4'd1, 32'h100); reg_write(4'd3, 32'h100);
    reg_write(4'd2, 32'd32);
    reg_write(4'd4, 32'h200); reg_write(4'd5, 32'h200);
    reg_write(4'd7, 32'h8);

    // work queued while disabled
    send(0, 32'h0000_1000, 12'd60, 15'd0, 0, 1, 0, 0, 0, 5'd0);
    send(1, 32'h0000_1800, 12'd1514, 15'd1, 0, 1, 0, 1, 0, 5'd3);
    n_memreq = 0;
    reg_write(4'd6, 32'd2);
    repeat (20) @(negedge clk);
    check("R2 no fetch while disabled", 32'(n_memreq), 0);
    reg_read(4'd10, d); check("R7 pending after enqueue", d, 2);

    reg_write(4'd0, 32'h1);
    drain();
    reg_read(4'd10, d); check("R7 pending drained", d, 0);
    reg_read(4'd3, d);  check("R8 descriptor pointer", d, 32'h110);
    check("R10 irq after completion", 32'(tx_irq), 1);
    reg_read(4'd8, d);  check("R10 plain view", d, 32'h8);
    check("R10 plain view keeps irq", 32'(tx_irq), 1);
    reg_read(4'd9, d);  check("R10 clear view value", d, 32'h8);
    check("R10 irq cleared", 32'(tx_irq), 0);
    reg_read(4'd8, d);  check("R10 flag cleared", d, 0);

    // abort, failing frame, index mismatch across the ring end
    send(2, 32'h0000_2000, 12'd100, 15'd2, 1, 1, 0, 0, 0, 5'd0);
    send(3, 32'h0000_2800, 12'd64, 15'd3, 0, 0, 1, 0, 1, 5'd31);
    send(0, 32'h0000_3000, 12'd4095, 15'h1234, 0, 1, 0, 0, 0, 5'd1);
    reg_write(4'd6, 32'd1);
    reg_write(4'd6, 32'd2);
    drain();
    reg_read(4'd3, d);  check("R8 descriptor pointer wrapped", d, 32'h108);
    reg_read(4'd5, d);  check("R9 status pointer wrapped", d, 32'h204);
    reg_read(4'd10, d); check("R7 pending drained again", d, 0);
    check("R6 aborted frame not offered", 32'(n_frames), 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule